// File: doc/BRIEF.md
# Multi-Latency Pipeline Interlock Unit

This block decides, for the instruction in decode, whether it may issue on the next edge and, if it may, where each of its source operands should be taken from. The pipeline is in order and single issue. It has a fetch stage, a decode stage, a chain of execute stages and one write-back stage. Each instruction class produces its result at the end of a different execute stage. After that, the result travels with the instruction and can be forwarded from every later stage.

The unit keeps a small shift register that mirrors the execute stages. Each entry records whether the occupant writes a register, which register, and the stage at whose end its result becomes valid. For each operand the unit finds the youngest in-flight writer of the same register. It stalls decode if that writer will not be ready by the cycle the operand is consumed. While stalled, a bubble goes into the first execute stage. Otherwise the unit returns a select code that names the stage output feeding the operand. Class encoding on `dec_class`: 0 integer, 1 divide, 2 load, 3 store, 4 add, 5 multiply.

Top module: `ilk_unit`

## Requirements
- R1: After reset no producer is tracked: a valid decode with any enabled sources gives stall low and both select codes 0.
- R2: Results become ready at the end of execute stage 1 for integer, 2 for divide, 3 for load and add, and 5 for multiply. An integer consumer directly behind an integer producer issues without stall, with select code 1.
- R3: A producer of ready stage r, followed by g independent instructions and then an operand needed at execute stage n, stalls decode for max(0, r-n-g) cycles. Zero-stall gaps for an ALU consumer are therefore 1 after divide, 2 after load or add, and 4 after multiply.
- R4: A store's data operand (source B) is needed only at the start of execute stage 2. Its address operand (source A) is needed at execute stage 1. A store's data directly behind a load stalls one cycle, and needs no stall with one instruction between them.
- R5: The select code is k+n-1. Here k is the producer's execute stage while the consumer is in decode, counted after any stall, and n is the stage where the operand is needed. Code 0 means the register file. Code NUM_EX+1 means the write-back stage output.
- R6: When several in-flight instructions write the same register, the operand follows the youngest one, and only that one can cause a stall.
- R7: Register 0 never forms a dependence, and neither does a disabled source: its select code is 0 and it causes no stall.
- R8: Stall is raised only for a valid decode. During a stalled cycle a bubble enters execute stage 1, so the held instruction enters exactly once, when the stall clears.
- R9: A store writes no register, so a later reader of the register in the store's destination field gets code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds a valid instruction |
| dec_class | input | 3 | Instruction class of the decoded instruction |
| dec_dst | input | REG_W | Destination register |
| dec_src_a | input | REG_W | Source A register (ALU operand or store address) |
| dec_use_a | input | 1 | Source A is read |
| dec_src_b | input | REG_W | Source B register (ALU operand or store data) |
| dec_use_b | input | 1 | Source B is read |
| stall | output | 1 | Hold decode and insert a bubble |
| byp_a | output | CODE_W | Select code for source A |
| byp_b | output | CODE_W | Select code for source B |

## Verification
On every cycle the checker confirms the following: no stall without a valid decode; a bubble in execute stage 1 after each stalled cycle; a zero code for register 0 or for a disabled source; and select codes that stay inside the range their need stage allows. The exact number of stall cycles for each producer and consumer pairing, and the stage that a code names, depend on the history of issued instructions. Only the bench's directed sequences show these: class pairs at several gaps, stores behind loads and multiplies, and a shadowed older producer.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

   typedef enum logic [2:0] {
      CL_INT   = 3'd0,
      CL_DIVF  = 3'd1,
      CL_LOAD  = 3'd2,
      CL_STORE = 3'd3,
      CL_ADDF  = 3'd4,
      CL_MULTF = 3'd5
   } op_class_e;

   // Execute stage at whose end the class's result is valid
   function automatic int unsigned ready_stage(input op_class_e c);
      case (c)
         CL_DIVF:  return 2;
         CL_LOAD:  return 3;
         CL_ADDF:  return 3;
         CL_MULTF: return 5;
         default:  return 1;
      endcase
   endfunction

   function automatic logic writes_reg(input op_class_e c);
      return (c != CL_STORE);
   endfunction

endpackage

// File: rtl/ilk_track.sv
module ilk_track #(
   parameter int REG_W  = 5,
   parameter int NUM_EX = 5,
   parameter int RDY_W  = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              ins_vld,
   input  logic                              ins_wr,
   input  logic [REG_W-1:0]                  ins_dst,
   input  logic [RDY_W-1:0]                  ins_rdy,
   output logic [NUM_EX-1:0]                 slot_vld,
   output logic [NUM_EX-1:0]                 slot_wr,
   output logic [NUM_EX-1:0][REG_W-1:0]      slot_dst,
   output logic [NUM_EX-1:0][RDY_W-1:0]      slot_rdy
);

   for (genvar i = 0; i < NUM_EX; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_vld[i] <= 1'b0;
               slot_wr[i]  <= 1'b0;
               slot_dst[i] <= '0;
               slot_rdy[i] <= '0;
            end else begin
               slot_vld[i] <= ins_vld;
               slot_wr[i]  <= ins_vld & ins_wr;
               slot_dst[i] <= ins_dst;
               slot_rdy[i] <= ins_rdy;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_vld[i] <= 1'b0;
               slot_wr[i]  <= 1'b0;
               slot_dst[i] <= '0;
               slot_rdy[i] <= '0;
            end else begin
               slot_vld[i] <= slot_vld[i-1];
               slot_wr[i]  <= slot_wr[i-1];
               slot_dst[i] <= slot_dst[i-1];
               slot_rdy[i] <= slot_rdy[i-1];
            end
         end
      end
   end

endmodule

// File: rtl/ilk_opnd.sv
module ilk_opnd #(
   parameter int REG_W  = 5,
   parameter int NUM_EX = 5,
   parameter int RDY_W  = 3,
   parameter int CODE_W = 3
) (
   input  logic                          use_i,
   input  logic [REG_W-1:0]              src_i,
   input  logic [1:0]                    need_i,
   input  logic [NUM_EX-1:0]             slot_wr,
   input  logic [NUM_EX-1:0][REG_W-1:0]  slot_dst,
   input  logic [NUM_EX-1:0][RDY_W-1:0]  slot_rdy,
   output logic                          hazard_o,
   output logic [CODE_W-1:0]             code_o
);

   // Walk oldest to youngest; the last match (youngest) wins
   always_comb begin
      hazard_o = 1'b0;
      code_o   = '0;
      for (int k = NUM_EX; k >= 1; k--) begin
         if (use_i && (src_i != '0) && slot_wr[k-1] && (slot_dst[k-1] == src_i)) begin
            hazard_o = (k + int'(need_i)) <= int'(slot_rdy[k-1]);
            code_o   = CODE_W'(k + int'(need_i) - 1);
         end
      end
   end

endmodule

// File: rtl/ilk_unit.sv
module ilk_unit
   import ilk_pkg::*;
#(
   parameter int REG_W  = 5,
   parameter int NUM_EX = 5,
   localparam int CODE_W = $clog2(NUM_EX + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dec_valid,
   input  logic [2:0]         dec_class,
   input  logic [REG_W-1:0]   dec_dst,
   input  logic [REG_W-1:0]   dec_src_a,
   input  logic               dec_use_a,
   input  logic [REG_W-1:0]   dec_src_b,
   input  logic               dec_use_b,
   output logic               stall,
   output logic [CODE_W-1:0]  byp_a,
   output logic [CODE_W-1:0]  byp_b
);

   localparam int RDY_W  = $clog2(NUM_EX + 1);
   localparam int N_OPND = 2;

   if (NUM_EX < 5) begin : g_bad_depth
      $error("ilk_unit: NUM_EX must cover the longest class latency (5)");
   end
   if (REG_W < 1) begin : g_bad_regw
      $error("ilk_unit: REG_W must be positive");
   end

   op_class_e             cls;
   logic                  ins_wr;
   logic [RDY_W-1:0]      ins_rdy;
   logic [NUM_EX-1:0]     slot_vld;
   logic [NUM_EX-1:0]     slot_wr;
   logic [NUM_EX-1:0][REG_W-1:0] slot_dst;
   logic [NUM_EX-1:0][RDY_W-1:0] slot_rdy;

   logic [N_OPND-1:0]              op_use;
   logic [N_OPND-1:0][REG_W-1:0]   op_src;
   logic [N_OPND-1:0][1:0]         op_need;
   logic [N_OPND-1:0]              op_haz;
   logic [N_OPND-1:0][CODE_W-1:0]  op_code;

   always_comb begin
      cls        = op_class_e'(dec_class);
      ins_wr     = writes_reg(cls) && (dec_dst != '0);
      ins_rdy    = RDY_W'(ready_stage(cls));
      op_use[0]  = dec_use_a;
      op_src[0]  = dec_src_a;
      op_need[0] = 2'd1;
      op_use[1]  = dec_use_b;
      op_src[1]  = dec_src_b;
      op_need[1] = (cls == CL_STORE) ? 2'd2 : 2'd1;
   end

   for (genvar o = 0; o < N_OPND; o++) begin : g_opnd
      ilk_opnd #(
         .REG_W  (REG_W),
         .NUM_EX (NUM_EX),
         .RDY_W  (RDY_W),
         .CODE_W (CODE_W)
      ) u_opnd (
         .use_i    (op_use[o]),
         .src_i    (op_src[o]),
         .need_i   (op_need[o]),
         .slot_wr  (slot_wr),
         .slot_dst (slot_dst),
         .slot_rdy (slot_rdy),
         .hazard_o (op_haz[o]),
         .code_o   (op_code[o])
      );
   end

   assign stall = dec_valid && (|op_haz);
   assign byp_a = op_code[0];
   assign byp_b = op_code[1];

   ilk_track #(
      .REG_W  (REG_W),
      .NUM_EX (NUM_EX),
      .RDY_W  (RDY_W)
   ) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .ins_vld  (dec_valid && !stall),
      .ins_wr   (ins_wr),
      .ins_dst  (dec_dst),
      .ins_rdy  (ins_rdy),
      .slot_vld (slot_vld),
      .slot_wr  (slot_wr),
      .slot_dst (slot_dst),
      .slot_rdy (slot_rdy)
   );

endmodule

// File: rtl/ilk_unit_chk.sv
module ilk_unit_chk #(
   parameter int REG_W  = 5,
   parameter int NUM_EX = 5,
   parameter int CODE_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dec_valid,
   input logic [2:0]         dec_class,
   input logic [REG_W-1:0]   dec_src_a,
   input logic               dec_use_a,
   input logic [REG_W-1:0]   dec_src_b,
   input logic               dec_use_b,
   input logic               stall,
   input logic [CODE_W-1:0]  byp_a,
   input logic [CODE_W-1:0]  byp_b,
   input logic               ex1_vld
);

   // R8
   idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !stall);

   // R8
   bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !ex1_vld);

   // R7
   zero_src_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_src_a == '0 || !dec_use_a) |-> (byp_a == '0));

   // R7
   zero_src_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_src_b == '0 || !dec_use_b) |-> (byp_b == '0));

   // R5
   code_a_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byp_a <= CODE_W'(NUM_EX));

   // R4
   code_b_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_class != 3'd3) |-> (byp_b <= CODE_W'(NUM_EX)));

endmodule

bind ilk_unit ilk_unit_chk #(
   .REG_W  (REG_W),
   .NUM_EX (NUM_EX),
   .CODE_W (CODE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dec_valid (dec_valid),
   .dec_class (dec_class),
   .dec_src_a (dec_src_a),
   .dec_use_a (dec_use_a),
   .dec_src_b (dec_src_b),
   .dec_use_b (dec_use_b),
   .stall     (stall),
   .byp_a     (byp_a),
   .byp_b     (byp_b),
   .ex1_vld   (slot_vld[0])
);

// File: tb/ilk_unit_tb.sv
`timescale 1ns/1ps
module ilk_unit_tb;

   localparam logic [2:0] C_INT = 3'd0, C_DIV = 3'd1, C_LD = 3'd2,
                          C_ST = 3'd3, C_ADD = 3'd4, C_MUL = 3'd5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dec_valid = 1'b0;
   logic [2:0] dec_class = 3'd0;
   logic [4:0] dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
   logic       dec_use_a = 1'b0, dec_use_b = 1'b0;
   logic       stall;
   logic [2:0] byp_a, byp_b;

   int n_chk = 0;
   int n_fail = 0;
   int last_stalls;
   logic [2:0] last_ca, last_cb;

   always #2 clk = ~clk;

   ilk_unit u_dut (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
      .dec_dst(dec_dst), .dec_src_a(dec_src_a), .dec_use_a(dec_use_a),
      .dec_src_b(dec_src_b), .dec_use_b(dec_use_b),
      .stall(stall), .byp_a(byp_a), .byp_b(byp_b)
   );

   function automatic int rdy_of(input logic [2:0] c);
      case (c)
         C_DIV:        return 2;
         C_LD, C_ADD:  return 3;
         C_MUL:        return 5;
         default:      return 1;
      endcase
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Present one instruction in decode until it issues
   task automatic send(input logic [2:0] c, input int dst, input int sa, input bit ua,
                       input int sb, input bit ub);
      @(negedge clk);
      dec_valid = 1'b1; dec_class = c; dec_dst = 5'(dst);
      dec_src_a = 5'(sa); dec_use_a = ua; dec_src_b = 5'(sb); dec_use_b = ub;
      last_stalls = 0;
      #1;
      while (stall) begin
         last_stalls++;
         @(negedge clk);
         #1;
      end
      last_ca = byp_a;
      last_cb = byp_b;
      @(posedge clk);
      #0.5;
      dec_valid = 1'b0;
   endtask

   task automatic nops(input int n);
      for (int i = 0; i < n; i++) send(C_INT, 0, 0, 0, 0, 0);
   endtask

   // Producer P writes r7, g independent instructions, then a consumer
   task automatic t_pair(input string req, input logic [2:0] p, input logic [2:0] c,
                         input bit data_op, input int g);
      int n, es, ec;
      nops(6);
      send(p, 7, 0, 0, 0, 0);
      for (int i = 0; i < g; i++) send(C_INT, 9, 10, 1, 11, 1);
      n  = (data_op && c == C_ST) ? 2 : 1;
      es = rdy_of(p) - n - g;
      if (es < 0) es = 0;
      ec = g + 1 + es + n - 1;
      if (data_op) send(c, 12, 3, 1, 7, 1);
      else         send(c, 12, 7, 1, 3, 1);
      chk(req, "stall cycles", last_stalls, es);
      chk(req, "select code", data_op ? int'(last_cb) : int'(last_ca), ec);
   endtask

   task automatic t_reset;
      @(negedge clk);
      dec_valid = 1'b1; dec_class = C_INT; dec_dst = 5'd4;
      dec_src_a = 5'd5; dec_use_a = 1'b1; dec_src_b = 5'd6; dec_use_b = 1'b1;
      #1;
      chk("R1", "stall after reset", int'(stall), 0);
      chk("R1", "code A after reset", int'(byp_a), 0);
      chk("R1", "code B after reset", int'(byp_b), 0);
      dec_valid = 1'b0;
   endtask

   task automatic t_youngest;
      nops(6);
      send(C_MUL, 7, 0, 0, 0, 0);
      send(C_INT, 7, 0, 0, 0, 0);
      send(C_INT, 12, 7, 1, 0, 0);
      chk("R6", "youngest stall", last_stalls, 0);
      chk("R6", "youngest code", int'(last_ca), 1);
   endtask

   task automatic t_no_dep;
      nops(6);
      send(C_INT, 0, 0, 0, 0, 0);
      send(C_INT, 12, 0, 1, 0, 1);
      chk("R7", "reg0 stall", last_stalls, 0);
      chk("R7", "reg0 code", int'(last_ca), 0);
      send(C_MUL, 8, 0, 0, 0, 0);
      send(C_INT, 12, 8, 0, 8, 0);
      chk("R7", "disabled source stall", last_stalls, 0);
      chk("R7", "disabled source code", int'(last_ca), 0);
   endtask

   task automatic t_store_nowrite;
      nops(6);
      send(C_ST, 7, 3, 1, 4, 1);
      send(C_INT, 12, 7, 1, 0, 0);
      chk("R9", "store dest stall", last_stalls, 0);
      chk("R9", "store dest code", int'(last_ca), 0);
   endtask

   task automatic t_bubble;
      nops(6);
      send(C_DIV, 7, 0, 0, 0, 0);
      send(C_INT, 8, 7, 1, 0, 0);
      chk("R8", "held stall", last_stalls, 1);
      send(C_INT, 12, 8, 1, 0, 0);
      chk("R8", "after-stall stall", last_stalls, 0);
      chk("R8", "after-stall code", int'(last_ca), 1);
      send(C_INT, 13, 8, 1, 0, 0);
      chk("R8", "single entry code", int'(last_ca), 2);
      send(C_MUL, 7, 0, 0, 0, 0);
      @(negedge clk);
      dec_class = C_INT; dec_src_a = 5'd7; dec_use_a = 1'b1; dec_valid = 1'b0;
      #1;
      chk("R8", "stall without valid", int'(stall), 0);
   endtask

   initial begin
      #200000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_pair("R2", C_INT, C_INT, 0, 0);
      t_pair("R3", C_DIV, C_INT, 0, 0);
      t_pair("R3", C_DIV, C_INT, 0, 1);
      t_pair("R3", C_LD,  C_INT, 0, 0);
      t_pair("R3", C_ADD, C_DIV, 0, 2);
      t_pair("R3", C_MUL, C_ADD, 0, 4);
      t_pair("R3", C_MUL, C_ADD, 0, 1);
      t_pair("R4", C_LD,  C_ST,  1, 1);
      t_pair("R4", C_LD,  C_ST,  1, 0);
      t_pair("R4", C_LD,  C_ST,  0, 0);
      t_pair("R5", C_MUL, C_ST,  1, 4);
      t_pair("R5", C_ADD, C_INT, 0, 3);
      t_youngest();
      t_no_dep();
      t_store_nowrite();
      t_bubble();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule